// File: doc/BRIEF.md
# PWM Channel with Hardware Duty Fade

This block turns one of several shared free-running timer counts into a single pulse-width-modulated output. The channel picks a timer, raises its output when that timer's count equals a programmed start point, and lowers it once a duty length has elapsed. The duty is a fixed-point quantity with four fractional bits. Those bits are turned into a per-period choice between the integer length and the integer length plus one, so that the mean high time over sixteen periods matches the fractional value exactly.

An autonomous fade engine can ramp the duty without processor help. A one-cycle start request captures a step size, a direction, a number of timer periods between steps and a number of steps. The engine then adds or subtracts the step at each qualifying period boundary, saturating at both ends. The request clears itself, and a one-cycle done pulse marks the end of the ramp. The working duty is always visible on a readback port.

Every pin is a plain control or status signal sampled on the clock. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Period boundaries come from each timer as a one-cycle strobe in that period's last count.

Top module: `pwm_fade_channel`

## Requirements
- R1: `tmr_sel_i` value k (0, 1, 2 or 3) routes count slice k (bits [20k+19:20k]) and period-end strobe bit k of the timer inputs to the channel; the other timers have no effect on the output.
- R2: With the channel enabled and no fractional part, `pwm_o` goes high the cycle after the selected count equals `hpoint_i`, and goes low the cycle after the count equals `hpoint_i` plus the integer duty. The output is high for exactly that many cycles per period. When both points coincide the low point wins, so an integer duty of 0 gives a constant low output.
- R3: A 4-bit accumulator adds the fraction `duty[3:0]` at every period-end strobe of the selected timer. Its carry makes the low point one count later in the following period, so over any 16 whole periods with a constant duty the output is high for 16*duty[24:4] + duty[3:0] cycles.
- R4: While `out_en_i` is 0, `pwm_o` equals the `idle_lvl_i` value of the previous cycle.
- R5: Reset clears `pwm_o`, `duty_o`, `fade_busy_o` and `fade_done_o` to 0. A one-cycle `duty_wr_i` loads `duty_wdata_i`, which appears on `duty_o` one cycle later. A write wins over a fade step in the same cycle.
- R6: A `fade_start_i` pulse with a nonzero step count captures the step, direction (`fade_up_i` = 1 increases), period count (0 is treated as 1) and step count, and sets `fade_busy_o`. At every period-count-th period-end strobe after that, the engine adds or subtracts the step (in units of duty LSB, 1/16 count). After the programmed number of steps, busy clears by itself.
- R7: Fade arithmetic saturates at 0 and at 2^25-1 and never wraps.
- R8: `fade_done_o` is a single-cycle pulse in the first cycle after the final step, the same cycle in which `fade_busy_o` is first low.
- R9: A `fade_start_i` pulse with a step count of 0 is ignored. Busy stays low, no done pulse occurs and the duty is unchanged.
- R10: Without a duty write and without an active fade, `duty_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tmr_cnt_i | input | 80 | Four 20-bit timer counts, timer k in bits [20k+19:20k] |
| tmr_end_i | input | 4 | Per-timer one-cycle strobe in the last count of a period |
| tmr_sel_i | input | 2 | Timer select |
| out_en_i | input | 1 | Output enable |
| idle_lvl_i | input | 1 | Level driven while disabled |
| hpoint_i | input | 20 | Count at which the output rises |
| duty_wr_i | input | 1 | Load the duty from `duty_wdata_i` |
| duty_wdata_i | input | 25 | New duty, [24:4] integer, [3:0] fraction |
| fade_start_i | input | 1 | One-cycle fade start request |
| fade_up_i | input | 1 | Fade direction, 1 increases |
| fade_step_i | input | 10 | Step size in duty LSBs |
| fade_period_i | input | 10 | Timer periods per step |
| fade_num_i | input | 10 | Number of steps |
| pwm_o | output | 1 | PWM output |
| duty_o | output | 25 | Working duty readback |
| fade_busy_o | output | 1 | Fade in progress |
| fade_done_o | output | 1 | Fade completion pulse |

## Verification
The bench measures the total high time over sixteen whole periods for fractions 0, 1, 3, 8, 12 and 15. A dither that drops or doubles its carry would miss the exact `16*int+frac` total. It selects a start point beyond timer 0's period, where a channel reading the wrong timer would pulse instead of staying low. It also checks a zero duty, where a design that let the high point win would stay high. The fades are driven into both rails, and a design that wrapped would read back a tiny or huge duty. A zero-step start is issued, and a design that honoured it would raise busy or emit a stray done. The bench also measures the time from start to done and the width of the done pulse, which catches an off-by-one period counter or a done that lasts two cycles.

// File: rtl/pwm_fade_pkg.sv
package pwm_fade_pkg;

  // Fade direction as captured from the start request
  typedef enum logic {
    FADE_DN = 1'b0,
    FADE_UP = 1'b1
  } fade_dir_e;

  // Width of a fixed-point low-point sum that cannot overflow
  function automatic int unsigned sum_width(input int unsigned a, input int unsigned b);
    return ((a > b) ? a : b) + 2;
  endfunction

endpackage

// File: rtl/pwm_timer_mux.sv
module pwm_timer_mux #(
  parameter int unsigned NUM_TMR = 4,
  parameter int unsigned CNT_W   = 20,
  localparam int unsigned SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic [NUM_TMR*CNT_W-1:0] cnt_bus_i,
  input  logic [NUM_TMR-1:0]       end_bus_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     end_o
);

  logic [CNT_W-1:0] cnt_arr [NUM_TMR];

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_unpack
    assign cnt_arr[k] = cnt_bus_i[k*CNT_W +: CNT_W];
  end

  always_comb begin
    cnt_o = '0;
    end_o = 1'b0;
    for (int k = 0; k < NUM_TMR; k++) begin
      if (sel_i == SEL_W'(k)) begin
        cnt_o = cnt_arr[k];
        end_o = end_bus_i[k];
      end
    end
  end

endmodule

// File: rtl/pwm_dither.sv
module pwm_dither #(
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              extra_o
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      extra_o <= 1'b0;
    end else if (end_i) begin
      acc_q   <= acc_sum[FRAC_W-1:0];
      extra_o <= acc_sum[FRAC_W];
    end
  end

endmodule

// File: rtl/pwm_fade_engine.sv
module pwm_fade_engine
  import pwm_fade_pkg::*;
#(
  parameter int unsigned DUTY_W = 25,
  parameter int unsigned STEP_W = 10,
  parameter int unsigned PER_W  = 10,
  parameter int unsigned NUM_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic              start_i,
  input  logic              up_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] wdata_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              busy_o,
  output logic              done_o,
  output fade_dir_e         dir_o
);

  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic [STEP_W-1:0] step_q;
  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  pcnt_q;
  logic [NUM_W-1:0]  left_q;
  logic              accept;
  logic              boundary;
  logic [PER_W-1:0]  per_last;
  logic [DUTY_W:0]   up_sum;
  logic [DUTY_W-1:0] step_ext;
  logic [DUTY_W-1:0] duty_next;

  assign accept   = start_i && (num_i != '0);
  assign per_last = (per_q == '0) ? '0 : per_q - 1'b1;
  assign boundary = busy_o && end_i && !accept && (pcnt_q == per_last);
  assign step_ext = DUTY_W'(step_q);
  assign up_sum   = {1'b0, duty_o} + {1'b0, step_ext};

  always_comb begin
    if (dir_o == FADE_UP) begin
      duty_next = up_sum[DUTY_W] ? DUTY_MAX : up_sum[DUTY_W-1:0];
    end else begin
      duty_next = (duty_o < step_ext) ? '0 : duty_o - step_ext;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      dir_o  <= FADE_DN;
      step_q <= '0;
      per_q  <= '0;
      pcnt_q <= '0;
      left_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_o <= 1'b1;
        dir_o  <= up_i ? FADE_UP : FADE_DN;
        step_q <= step_i;
        per_q  <= period_i;
        pcnt_q <= '0;
        left_q <= num_i;
      end else if (busy_o && end_i) begin
        if (boundary) begin
          pcnt_q <= '0;
          left_q <= left_q - 1'b1;
          if (left_q == NUM_W'(1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      duty_o <= '0;
    end else if (wr_i) begin
      duty_o <= wdata_i;
    end else if (boundary) begin
      duty_o <= duty_next;
    end
  end

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
  import pwm_fade_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned INT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hpoint_i,
  input  logic [INT_W-1:0] len_i,
  input  logic             extra_i,
  input  logic             en_i,
  input  logic             idle_i,
  output logic             pwm_o
);

  localparam int unsigned LW = sum_width(CNT_W, INT_W);

  logic [LW-1:0] lpoint;
  logic [LW-1:0] cnt_ext;
  logic          level_q;
  logic          level_n;

  assign lpoint  = LW'(hpoint_i) + LW'(len_i) + LW'(extra_i);
  assign cnt_ext = LW'(cnt_i);

  // The low point wins over the high point when they coincide
  always_comb begin
    if (cnt_ext == lpoint)        level_n = 1'b0;
    else if (cnt_i == hpoint_i)   level_n = 1'b1;
    else                          level_n = level_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      pwm_o   <= 1'b0;
    end else begin
      level_q <= level_n;
      pwm_o   <= en_i ? level_n : idle_i;
    end
  end

endmodule

// File: rtl/pwm_fade_channel.sv
module pwm_fade_channel
  import pwm_fade_pkg::*;
#(
  parameter int unsigned NUM_TMR = 4,
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned INT_W   = 21,
  parameter int unsigned FRAC_W  = 4,
  parameter int unsigned STEP_W  = 10,
  parameter int unsigned PER_W   = 10,
  parameter int unsigned NUM_W   = 10,
  localparam int unsigned DUTY_W = INT_W + FRAC_W,
  localparam int unsigned SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt_i,
  input  logic [NUM_TMR-1:0]       tmr_end_i,
  input  logic [SEL_W-1:0]         tmr_sel_i,
  input  logic                     out_en_i,
  input  logic                     idle_lvl_i,
  input  logic [CNT_W-1:0]         hpoint_i,
  input  logic                     duty_wr_i,
  input  logic [DUTY_W-1:0]        duty_wdata_i,
  input  logic                     fade_start_i,
  input  logic                     fade_up_i,
  input  logic [STEP_W-1:0]        fade_step_i,
  input  logic [PER_W-1:0]         fade_period_i,
  input  logic [NUM_W-1:0]         fade_num_i,
  output logic                     pwm_o,
  output logic [DUTY_W-1:0]        duty_o,
  output logic                     fade_busy_o,
  output logic                     fade_done_o
);

  logic [CNT_W-1:0] sel_cnt;
  logic             sel_end;
  logic             extra_w;
  fade_dir_e        fade_dir_w;

  pwm_timer_mux #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_mux (
    .cnt_bus_i (tmr_cnt_i),
    .end_bus_i (tmr_end_i),
    .sel_i     (tmr_sel_i),
    .cnt_o     (sel_cnt),
    .end_o     (sel_end)
  );

  pwm_dither #(.FRAC_W(FRAC_W)) u_dither (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .end_i   (sel_end),
    .frac_i  (duty_o[FRAC_W-1:0]),
    .extra_o (extra_w)
  );

  pwm_fade_engine #(
    .DUTY_W(DUTY_W), .STEP_W(STEP_W), .PER_W(PER_W), .NUM_W(NUM_W)
  ) u_fade (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .end_i    (sel_end),
    .start_i  (fade_start_i),
    .up_i     (fade_up_i),
    .step_i   (fade_step_i),
    .period_i (fade_period_i),
    .num_i    (fade_num_i),
    .wr_i     (duty_wr_i),
    .wdata_i  (duty_wdata_i),
    .duty_o   (duty_o),
    .busy_o   (fade_busy_o),
    .done_o   (fade_done_o),
    .dir_o    (fade_dir_w)
  );

  pwm_compare_out #(.CNT_W(CNT_W), .INT_W(INT_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (sel_cnt),
    .hpoint_i (hpoint_i),
    .len_i    (duty_o[DUTY_W-1:FRAC_W]),
    .extra_i  (extra_w),
    .en_i     (out_en_i),
    .idle_i   (idle_lvl_i),
    .pwm_o    (pwm_o)
  );

endmodule

// File: rtl/pwm_fade_channel_chk.sv
module pwm_fade_channel_chk
  import pwm_fade_pkg::*;
#(
  parameter int unsigned DUTY_W = 25
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_en_i,
  input logic              idle_lvl_i,
  input logic              pwm_o,
  input logic              duty_wr_i,
  input logic [DUTY_W-1:0] duty_o,
  input logic              fade_busy_o,
  input logic              fade_done_o,
  input fade_dir_e         dir_i
);

  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> (pwm_o == $past(idle_lvl_i)));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fade_done_o |=> !fade_done_o);

  p_done_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fade_busy_o) |-> fade_done_o);

  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fade_done_o |-> ($past(fade_busy_o) && !fade_busy_o));

  p_duty_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(duty_wr_i) && !$past(fade_busy_o)) |-> $stable(duty_o));

  p_no_wrap_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fade_busy_o) && !$past(duty_wr_i) && ($past(dir_i) == FADE_UP))
      |-> (duty_o >= $past(duty_o)));

  p_no_wrap_dn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fade_busy_o) && !$past(duty_wr_i) && ($past(dir_i) == FADE_DN))
      |-> (duty_o <= $past(duty_o)));

endmodule

bind pwm_fade_channel pwm_fade_channel_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_en_i    (out_en_i),
  .idle_lvl_i  (idle_lvl_i),
  .pwm_o       (pwm_o),
  .duty_wr_i   (duty_wr_i),
  .duty_o      (duty_o),
  .fade_busy_o (fade_busy_o),
  .fade_done_o (fade_done_o),
  .dir_i       (fade_dir_w)
);

// File: tb/sim_pwm_fade_channel.sv
`timescale 1ns/1ps
module sim_pwm_fade_channel;

  localparam int CLK_PERIOD = 10;
  localparam int PER [4] = '{32, 40, 48, 56};
  localparam logic [24:0] DMAX = 25'h1FFFFFF;

  typedef struct packed {
    logic [1:0]  sel;
    logic [19:0] hp;
    logic [20:0] ip;
    logic [3:0]  fr;
    logic        en;
    logic        idle;
    logic [15:0] exp_hi;
  } vec_t;

  // sel, hpoint, int, frac, en, idle, expected high cycles over 16 periods
  localparam vec_t VEC [10] = '{
    '{2'd0, 20'd4,  21'd10, 4'd0,  1'b1, 1'b0, 16'd160},
    '{2'd0, 20'd4,  21'd10, 4'd8,  1'b1, 1'b0, 16'd168},
    '{2'd1, 20'd2,  21'd7,  4'd3,  1'b1, 1'b0, 16'd115},
    '{2'd2, 20'd36, 21'd5,  4'd15, 1'b1, 1'b0, 16'd95},
    '{2'd0, 20'd36, 21'd5,  4'd15, 1'b1, 1'b0, 16'd0},
    '{2'd3, 20'd10, 21'd0,  4'd0,  1'b1, 1'b0, 16'd0},
    '{2'd3, 20'd10, 21'd0,  4'd1,  1'b1, 1'b0, 16'd1},
    '{2'd1, 20'd3,  21'd20, 4'd0,  1'b0, 1'b1, 16'd640},
    '{2'd1, 20'd3,  21'd20, 4'd0,  1'b0, 1'b0, 16'd0},
    '{2'd2, 20'd1,  21'd12, 4'd12, 1'b1, 1'b0, 16'd204}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] tcnt [4];
  logic [79:0] tmr_cnt;
  logic [3:0]  tmr_end;
  logic [1:0]  sel = '0;
  logic        en = 1'b0, idle = 1'b0;
  logic [19:0] hp = '0;
  logic        dwr = 1'b0;
  logic [24:0] dwd = '0;
  logic        fstart = 1'b0, fup = 1'b0;
  logic [9:0]  fstep = '0, fper = '0, fnum = '0;
  logic        pwm;
  logic [24:0] duty;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < 4; k++) begin : g_tmr
    initial tcnt[k] = '0;
    always @(negedge clk) tcnt[k] <= (tcnt[k] == 20'(PER[k] - 1)) ? '0 : tcnt[k] + 1'b1;
    assign tmr_cnt[k*20 +: 20] = tcnt[k];
    assign tmr_end[k] = (tcnt[k] == 20'(PER[k] - 1));
  end

  pwm_fade_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .tmr_cnt_i(tmr_cnt), .tmr_end_i(tmr_end),
    .tmr_sel_i(sel), .out_en_i(en), .idle_lvl_i(idle), .hpoint_i(hp),
    .duty_wr_i(dwr), .duty_wdata_i(dwd), .fade_start_i(fstart), .fade_up_i(fup),
    .fade_step_i(fstep), .fade_period_i(fper), .fade_num_i(fnum),
    .pwm_o(pwm), .duty_o(duty), .fade_busy_o(busy), .fade_done_o(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic write_duty(input logic [24:0] v);
    @(negedge clk); dwr = 1'b1; dwd = v;
    @(negedge clk); dwr = 1'b0;
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  // Starts a fade and waits for completion; returns cycles to done and done-high count
  task automatic run_fade(input logic up, input int step, input int per, input int num,
                          output int elapsed, output int done_hi);
    @(negedge clk);
    fstart = 1'b1; fup = up; fstep = 10'(step); fper = 10'(per); fnum = 10'(num);
    @(negedge clk); fstart = 1'b0;
    elapsed = 1; done_hi = 0;
    while (!done && elapsed < 20000) begin
      @(negedge clk); elapsed++;
    end
    for (int i = 0; i < 40; i++) begin
      if (done) done_hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    int hi, el, dh;
    logic [24:0] d0;
    repeat (4) @(negedge clk);
    // R5: reset state
    check("R5 reset pwm", pwm, 0);
    check("R5 reset duty", duty, 0);
    check("R5 reset busy", busy, 0);
    check("R5 reset done", done, 0);
    rst_n = 1'b1;

    // R5: write appears one cycle later
    @(negedge clk); dwr = 1'b1; dwd = 25'd12345;
    @(negedge clk); dwr = 1'b0;
    check("R5 readback", duty, 12345);

    // Table walk: R1 R2 R3 R4
    foreach (VEC[i]) begin
      @(negedge clk);
      sel = VEC[i].sel; hp = VEC[i].hp; en = VEC[i].en; idle = VEC[i].idle;
      write_duty({VEC[i].ip, VEC[i].fr});
      repeat (2 * PER[VEC[i].sel]) @(negedge clk);
      count_high(16 * PER[VEC[i].sel], hi);
      check($sformatf("R1/R2/R3/R4 vector %0d", i), hi, VEC[i].exp_hi);
    end

    // R10: duty holds with no write and no fade
    d0 = duty;
    repeat (100) @(negedge clk);
    check("R10 duty stable", duty, d0);

    // R6/R8: fade up 3 steps of one count, every 2 periods of timer 0
    sel = 2'd0; hp = 20'd2; en = 1'b1;
    write_duty(25'd80);
    run_fade(1'b1, 16, 2, 3, el, dh);
    check("R6 fade up final duty", duty, 128);
    check("R6 busy cleared", busy, 0);
    check("R6 duration within window", (el > 5 * PER[0] && el <= 6 * PER[0] + 2) ? 1 : 0, 1);
    check("R8 done pulse width", dh, 1);

    // R7: saturate at zero going down
    write_duty(25'd20);
    run_fade(1'b0, 16, 1, 3, el, dh);
    check("R7 saturate at 0", duty, 0);

    // R7: saturate at maximum going up
    write_duty(DMAX - 25'd5);
    run_fade(1'b1, 16, 1, 2, el, dh);
    check("R7 saturate at max", duty, DMAX);

    // R6: period count 0 acts as 1, decreasing
    write_duty(25'd100);
    run_fade(1'b0, 7, 0, 4, el, dh);
    check("R6 period zero as one", duty, 72);
    check("R6 period zero duration", (el <= 4 * PER[0] + 2) ? 1 : 0, 1);

    // R9: zero-step start ignored
    write_duty(25'd50);
    @(negedge clk);
    fstart = 1'b1; fup = 1'b1; fstep = 10'd16; fper = 10'd1; fnum = 10'd0;
    @(negedge clk); fstart = 1'b0;
    check("R9 busy not set", busy, 0);
    dh = 0;
    for (int i = 0; i < 3 * PER[0]; i++) begin
      @(negedge clk);
      if (done) dh++;
    end
    check("R9 no done", dh, 0);
    check("R9 duty unchanged", duty, 50);

    summary();
    $finish;
  end

endmodule